// File: doc/BRIEF.md
# Wait-State Flash Strobe Generator

This block drives a byte-wide flash or LCD bus. It produces the active-low read strobe, the write strobe, the chip enable and the output-enable for the data lines. A buffer-side master hands it one-byte transfers over a valid/ready request channel. Each transfer is one strobe: a low phase followed by a high phase. Both phases last (1+n) clocks, where n is a 6-bit wait-state count.

For a read, the byte on the bus is captured on the last clock of the low phase. It is offered on a valid/ready response channel once the high phase has ended. Every transfer ends with a one-clock completion pulse, and an interrupt pulse goes with it when interrupts are enabled.

A mode pin selects how chip enable behaves. In one setting it frames each single transfer. In the other it stays asserted across a run of transfers for as long as the master keeps a request pending. A level-sensitive soft reset aborts any transfer in flight.

Top module: `flash_strobe_gen`

## Requirements
- R1: After reset the strobes, chip enable and completion pulse are inactive (`bus_re_n`, `bus_we_n` and `bus_ce_n` high; `xfer_done`, `irq` and `rsp_valid` low), and `req_ready` is high.
- R2: The strobe of an accepted transfer is low for exactly `cfg_wait`+1 clocks. The value used is the one sampled at acceptance, for any value 0 to 63.
- R3: After the low phase, the strobe is high for exactly `cfg_wait`+1 clocks. `xfer_done` is then high for one clock.
- R4: A read (`req_write`=0) lowers `bus_re_n` only. The byte present on `bus_din` during the last low clock is returned on `rsp_rdata`, with `rsp_valid` rising in the same clock as `xfer_done`.
- R5: A write (`req_write`=1) lowers `bus_we_n` only. `bus_dout` carries `req_wdata` and `bus_oe` is high while the strobe is low.
- R6: `req_ready` is high only when no transfer is running, no response is pending and soft reset is low. A request is taken in a clock where `req_valid` and `req_ready` are both high.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` holds its value.
- R8: With `cfg_ce_hold`=0, `bus_ce_n` is low throughout the low and high phases and high in the completion clock.
- R9: With `cfg_ce_hold`=1, `bus_ce_n` stays low through the completion clock and the idle clocks that follow, as long as `req_valid` is held high. It goes high in an idle clock where `req_valid` is low.
- R10: `irq` pulses in the same clock as `xfer_done` when `cfg_irq_en`=1, and stays low when `cfg_irq_en`=0.
- R11: One clock after `cfg_soft_rst` goes high, all strobes and chip enable are inactive, `xfer_done` and `rsp_valid` are low, and the aborted transfer never completes.
- R12: `bus_re_n` and `bus_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ce_hold | input | 1 | 1: chip enable held across back-to-back transfers; 0: per transfer |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_soft_rst | input | 1 | Soft reset, level sensitive |
| cfg_wait | input | 6 | Wait-state count n |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 8 | Read byte |
| xfer_done | output | 1 | One-clock completion pulse |
| irq | output | 1 | Interrupt pulse |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_dout | output | 8 | Write data to the bus |
| bus_din | input | 8 | Read data from the bus |

## Verification
The bench's bus model changes `bus_din` on every low-phase clock. A design that samples one clock early or late therefore returns a different byte. Strobe widths are measured at n = 0, 1, 5 and 63. This catches off-by-one phase counters and designs that stretch only one of the two phases. Back-to-back transfers in both chip-enable modes show whether chip enable wrongly drops between transfers, or wrongly stays low between them. A stalled response must block new requests and hold its data, and a soft reset in mid-strobe must leave no completion or response behind.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } fsg_state_e;
endpackage

// File: rtl/fsg_phase_timer.sv
module fsg_phase_timer #(
  parameter int WAIT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              zero
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fsg_seq.sv
module fsg_seq #(
  parameter int WAIT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               irq_en,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               rsp_busy,
  input  logic               tm_zero,
  output logic               req_ready,
  output logic               accept,
  output logic               tm_load,
  output logic [WAIT_W-1:0]  tm_val,
  output fsg_pkg::fsg_state_e st,
  output logic               wr_q,
  output logic               low_last,
  output logic               high_last,
  output logic               done,
  output logic               irq,
  output logic               re_n,
  output logic               we_n
);
  import fsg_pkg::*;

  fsg_state_e        st_q;
  logic [WAIT_W-1:0] n_q;

  assign req_ready = (st_q == ST_IDLE) && !rsp_busy && !soft_rst;
  assign accept    = req_valid && req_ready;
  assign low_last  = (st_q == ST_LOW)  && tm_zero;
  assign high_last = (st_q == ST_HIGH) && tm_zero;
  assign tm_load   = accept || low_last;
  assign tm_val    = accept ? cfg_wait : n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wr_q <= 1'b0;
      n_q  <= '0;
      done <= 1'b0;
      irq  <= 1'b0;
    end else if (soft_rst) begin
      st_q <= ST_IDLE;
      wr_q <= 1'b0;
      n_q  <= '0;
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      done <= high_last;
      irq  <= high_last && irq_en;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q <= ST_LOW;
          wr_q <= req_write;
          n_q  <= cfg_wait;
        end
        ST_LOW:  if (tm_zero) st_q <= ST_HIGH;
        ST_HIGH: if (tm_zero) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st   = st_q;
  assign re_n = !((st_q == ST_LOW) && !wr_q);
  assign we_n = !((st_q == ST_LOW) &&  wr_q);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    re_n || we_n);

  // R11
  soft_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (re_n && we_n && !done && !irq && st_q == ST_IDLE));

  // R10
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  // R6
  ready_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_busy || st_q != ST_IDLE) |-> !req_ready);

  // R3
  done_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    done |-> $past(st_q == ST_HIGH));
endmodule

// File: rtl/fsg_datapath.sv
module fsg_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wr_q,
  input  logic              low_last,
  input  logic              high_last,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] bus_dout
);
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdata_q <= '0;
    else if (accept)  wdata_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rdata_q <= '0;
    else if (low_last && !wr_q)  rdata_q <= bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   vld_q <= 1'b0;
    else if (soft_rst)            vld_q <= 1'b0;
    else if (high_last && !wr_q)  vld_q <= 1'b1;
    else if (rsp_ready)           vld_q <= 1'b0;
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = rdata_q;
  assign bus_dout  = wdata_q;

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (vld_q && !rsp_ready) |=> (vld_q && $stable(rdata_q)));

  // R11
  rsp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !vld_q);
endmodule

// File: rtl/fsg_ce_ctrl.sv
module fsg_ce_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                ce_hold,
  input  logic                req_valid,
  input  fsg_pkg::fsg_state_e st,
  output logic                ce_n
);
  import fsg_pkg::*;

  logic keep_q;
  logic busy;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           keep_q <= 1'b0;
    else if (soft_rst)    keep_q <= 1'b0;
    else if (busy)        keep_q <= 1'b1;
    else if (!req_valid)  keep_q <= 1'b0;
  end

  assign ce_n = !(busy || (ce_hold && keep_q && req_valid && !soft_rst));

  // R8
  ce_idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_hold && st == ST_IDLE) |-> ce_n);

  // R9
  ce_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !req_valid) |-> ce_n);
endmodule

// File: rtl/flash_strobe_gen.sv
module flash_strobe_gen #(
  parameter int WAIT_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ce_hold,
  input  logic              cfg_irq_en,
  input  logic              cfg_soft_rst,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              xfer_done,
  output logic              irq,
  output logic              bus_re_n,
  output logic              bus_we_n,
  output logic              bus_ce_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  import fsg_pkg::*;

  logic              accept, tm_load, tm_zero, wr_q, low_last, high_last;
  logic [WAIT_W-1:0] tm_val;
  fsg_state_e        st;

  fsg_phase_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cfg_soft_rst),
    .load(tm_load), .load_val(tm_val), .zero(tm_zero)
  );

  fsg_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(cfg_soft_rst), .irq_en(cfg_irq_en),
    .cfg_wait(cfg_wait), .req_valid(req_valid), .req_write(req_write),
    .rsp_busy(rsp_valid), .tm_zero(tm_zero), .req_ready(req_ready),
    .accept(accept), .tm_load(tm_load), .tm_val(tm_val), .st(st),
    .wr_q(wr_q), .low_last(low_last), .high_last(high_last),
    .done(xfer_done), .irq(irq), .re_n(bus_re_n), .we_n(bus_we_n)
  );

  fsg_datapath #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .soft_rst(cfg_soft_rst), .accept(accept),
    .req_wdata(req_wdata), .wr_q(wr_q), .low_last(low_last),
    .high_last(high_last), .bus_din(bus_din), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_dout(bus_dout)
  );

  fsg_ce_ctrl u_ce (
    .clk(clk), .rst_n(rst_n), .soft_rst(cfg_soft_rst), .ce_hold(cfg_ce_hold),
    .req_valid(req_valid), .st(st), .ce_n(bus_ce_n)
  );

  assign bus_oe = wr_q && (st != ST_IDLE);

  // R5
  oe_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> bus_oe);
endmodule

// File: tb/flash_strobe_gen_tb_top.sv
module flash_strobe_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ce_hold = 1'b0, cfg_irq_en = 1'b0, cfg_soft_rst = 1'b0;
  logic [5:0] cfg_wait = '0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_wdata = '0, bus_din = 8'hEE;
  logic req_ready, rsp_valid, xfer_done, irq, bus_re_n, bus_we_n, bus_ce_n, bus_oe;
  logic [7:0] rsp_rdata, bus_dout;

  always #4 clk = ~clk;

  flash_strobe_gen dut_i (.*);

  typedef struct { bit wr; logic [7:0] d; int n; bit chk; } item_t;
  item_t exp_q[$];
  logic [7:0] rd_q[$];
  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  item_t cur;
  bit in_lo = 0, in_hi = 0, rsp_seen = 0;
  int lo_cnt = 0, hi_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n || cfg_soft_rst) begin
      in_lo = 0; in_hi = 0; bus_din = 8'hEE;
    end else begin
      if (!(bus_re_n && bus_we_n)) begin
        if (!in_lo) begin
          in_lo = 1; in_hi = 0; lo_cnt = 0;
          if (exp_q.size() > 0) cur = exp_q.pop_front();
          else begin cur.chk = 1; cur.n = -1; cur.wr = 0; cur.d = 0; end
          if (cur.chk) begin
            check(bus_re_n != bus_we_n, "R12", {bus_re_n, bus_we_n}, 1);
            if (cur.wr) begin
              check(!bus_we_n && bus_re_n, "R5", bus_we_n, 0);
              check(bus_dout == cur.d && bus_oe, "R5", bus_dout, cur.d);
            end else begin
              check(!bus_re_n && bus_we_n, "R4", bus_re_n, 0);
              rd_q.push_back(cur.d + 8'(cur.n));
            end
          end
        end
        if (cur.chk) check(!bus_ce_n, "R8", bus_ce_n, 0);
        bus_din = cur.d + 8'(lo_cnt);
        lo_cnt++;
      end else begin
        bus_din = 8'hEE;
        if (in_lo) begin
          in_lo = 0; in_hi = 1; hi_cnt = 0;
          if (cur.chk) check(lo_cnt == cur.n + 1, "R2", lo_cnt, cur.n + 1);
        end
        if (in_hi) begin
          if (xfer_done) begin
            in_hi = 0;
            if (cur.chk) begin
              check(hi_cnt == cur.n + 1, "R3", hi_cnt, cur.n + 1);
              check(irq == cfg_irq_en, "R10", irq, cfg_irq_en);
              if (cfg_ce_hold && req_valid) check(!bus_ce_n, "R9", bus_ce_n, 0);
              else if (!cfg_ce_hold)        check(bus_ce_n, "R8", bus_ce_n, 1);
              if (!cur.wr) check(rsp_valid, "R4", rsp_valid, 1);
            end
          end else begin
            if (cur.chk) check(!bus_ce_n, "R8", bus_ce_n, 0);
            hi_cnt++;
          end
        end
      end
      if (rsp_valid && !rsp_seen) begin
        rsp_seen = 1;
        if (rd_q.size() > 0) begin
          logic [7:0] e;
          e = rd_q.pop_front();
          check(rsp_rdata == e, "R4", rsp_rdata, e);
        end else check(0, "R4", rsp_rdata, 0);
      end
      if (!rsp_valid) rsp_seen = 0;
    end
  end

  // driver: leaves req_valid high on return
  task automatic issue(bit wr, logic [7:0] d, int n, bit chk = 1);
    item_t it;
    @(negedge clk);
    cfg_wait = 6'(n); req_write = wr; req_wdata = d; req_valid = 1;
    while (!req_ready) @(negedge clk);
    it.wr = wr; it.d = d; it.n = n; it.chk = chk;
    exp_q.push_back(it);
  endtask

  task automatic release_req();
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (!(req_ready && !xfer_done && bus_re_n && bus_we_n) && g < 400) begin
      @(negedge clk); g++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(bus_re_n && bus_we_n && bus_ce_n, "R1", {bus_re_n, bus_we_n, bus_ce_n}, 7);
    check(!xfer_done && !irq && !rsp_valid, "R1", {xfer_done, irq, rsp_valid}, 0);
    check(req_ready, "R1", req_ready, 1);

    // per-transfer chip enable, widths across wait values (R2 R3 R4 R5 R8)
    issue(0, 8'h10, 0); release_req(); wait_idle();
    issue(1, 8'hA5, 1); release_req(); wait_idle();
    issue(0, 8'h30, 5); release_req(); wait_idle();
    issue(1, 8'h5A, 63); release_req(); wait_idle();
    issue(0, 8'h40, 63); release_req(); wait_idle();

    // R10 interrupt enabled
    cfg_irq_en = 1;
    issue(1, 8'h77, 2); release_req(); wait_idle();
    issue(0, 8'h50, 3); release_req(); wait_idle();
    cfg_irq_en = 0;

    // R8 back-to-back in per-transfer mode, R9 hold mode
    issue(1, 8'h01, 1); issue(1, 8'h02, 1); release_req(); wait_idle();
    cfg_ce_hold = 1;
    issue(1, 8'h11, 2); issue(0, 8'h60, 1); issue(1, 8'h13, 0); release_req();
    @(negedge clk);
    wait_idle();
    check(bus_ce_n, "R9", bus_ce_n, 1);
    cfg_ce_hold = 0;

    // R7 / R6 response back-pressure
    rsp_ready = 0;
    issue(0, 8'h80, 2); release_req();
    while (!rsp_valid) @(negedge clk);
    begin
      logic [7:0] held;
      held = rsp_rdata;
      repeat (5) @(negedge clk);
      check(rsp_valid && rsp_rdata == held, "R7", rsp_rdata, held);
      check(!req_ready, "R6", req_ready, 0);
      req_valid = 1; req_write = 1;
      repeat (3) @(negedge clk);
      check(bus_we_n && bus_re_n, "R6", bus_we_n, 1);
      req_valid = 0;
    end
    rsp_ready = 1;
    wait_idle();
    check(req_ready, "R6", req_ready, 1);

    // R11 soft reset mid-strobe
    cfg_irq_en = 1;
    issue(0, 8'h90, 10, 0); release_req();
    repeat (4) @(negedge clk);
    cfg_soft_rst = 1;
    @(negedge clk);
    check(bus_re_n && bus_we_n && bus_ce_n, "R11", {bus_re_n, bus_we_n, bus_ce_n}, 7);
    check(!req_ready, "R11", req_ready, 0);
    begin
      bit seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (xfer_done || irq || rsp_valid || !bus_re_n) seen = 1;
      end
      check(!seen, "R11", seen, 0);
    end
    cfg_soft_rst = 0;
    @(negedge clk);
    check(req_ready && bus_ce_n, "R11", req_ready, 1);
    cfg_irq_en = 0;
    issue(0, 8'hC0, 4); release_req(); wait_idle();
    check(exp_q.size() == 0 && rd_q.size() == 0, "R4", exp_q.size(), 0);

    finish_run();
  end
endmodule